// File: doc/BRIEF.md
# Half-Bridge Driver Fault and Sleep Supervisor

This block is the digital supervisor of a four-channel half-bridge power stage. Comparators outside the block report supply undervoltage, charge-pump undervoltage, overcurrent on each channel and overtemperature. The supervisor turns these flags into a per-channel drive-enable mask, a charge-pump enable, a ready flag and an active-low fault output. Each fault class follows its own rules. The two undervoltage faults recover by themselves. Overcurrent and overtemperature stay latched until they are cleared.

The active-low sleep input has two uses, and the block tells them apart by how long the input stays low. A short low pulse of at least `CLR_NS` clears the latched faults and leaves the driver awake. A low time of `SLEEP_NS` puts the driver to sleep. After the driver leaves sleep, and after the supply leaves undervoltage, all drive stays off and ready stays low for a wake interval of `WAKE_NS`. Every time is given in nanoseconds and converted to clock cycles using `CLK_MHZ`. All flag inputs are expected to be synchronous to `clk`.

Top module: `hb_fault_supervisor`

## Requirements
- R1: While `uv_supply_i` is high, the next clock edge clears `drv_en_o`, `pump_en_o` and `ready_o` and drives `fault_n_o` low. Supply undervoltage also erases every latched fault. When the flag drops, `fault_n_o` rises on the next edge and the wake sequence of R9 restarts.
- R2: While `uv_pump_i` is high, the next edge clears all of `drv_en_o` and drives `fault_n_o` low, and `pump_en_o` and `ready_o` stay high. One edge after the flag drops, drive and `fault_n_o` are restored.
- R3: When `oc_i[i]` is sampled high on DEG consecutive edges (DEG = OCP_NS·CLK_MHZ/1000), overcurrent on channel i is latched. One edge later only bit i of `drv_en_o` (bit i belongs to channel i) clears, and `fault_n_o` goes low. The other channels and the pump keep running.
- R4: An overcurrent flag high for only DEG−1 edges latches nothing. A flag that drops for one edge restarts the count.
- R5: When `ot_i` is high, the overtemperature fault is latched. Two edges later all drive and `pump_en_o` are off and `fault_n_o` is low. These stay in place after `ot_i` drops.
- R6: When `sleep_n_i` is sampled low on CLR consecutive edges (CLR = CLR_NS·CLK_MHZ/1000), every latched overcurrent is cleared and drive returns without sleeping. A low pulse of CLR−1 edges clears nothing.
- R7: A clear pulse leaves the overtemperature latch set while `ot_i` is still high. A clear pulse given after `ot_i` has dropped releases it.
- R8: When `sleep_n_i` is sampled low on SLP consecutive edges (SLP = SLEEP_NS·CLK_MHZ/1000), the block enters sleep, and one edge later drive, pump and ready are all off. A low time between CLR and SLP−1 edges does not sleep.
- R9: After reset, after sleep ends (`sleep_n_i` sampled high) and after supply undervoltage ends, `ready_o` and `drv_en_o` stay off for WAKE cycles and rise two edges after that. `pump_en_o` is already high during the wake interval.
- R10: After reset, with no fault flag present, `fault_n_o` is high and all other outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sleep_n_i | input | 1 | Active-low sleep / fault-clear input |
| uv_supply_i | input | 1 | Supply undervoltage flag |
| uv_pump_i | input | 1 | Charge-pump undervoltage flag |
| oc_i | input | NCH | Per-channel overcurrent flags |
| ot_i | input | 1 | Overtemperature flag |
| drv_en_o | output | NCH | Per-channel half-bridge enable |
| pump_en_o | output | 1 | Charge-pump enable |
| ready_o | output | 1 | Driver awake and past wake interval |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
Some results take one edge: undervoltage on either supply reaches the outputs on the edge that samples the flag. Others take two: an overtemperature flag and the end of an overcurrent or sleep count pass through a latch or state register first, so they reach the outputs one edge later. The bench drives inputs on the falling edge, so the number of rising edges between a stimulus and a check is exact. The timing windows are checked at their edges: an overcurrent of DEG−1 against DEG edges, a low pulse of CLR−1 against CLR edges, and sleep just before and just after SLP edges. Wake is checked after exactly WAKE edges (still off) and after WAKE+2 edges (on).

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [1:0] {
    PWR_OFF   = 2'd0,
    PWR_WAKE  = 2'd1,
    PWR_RUN   = 2'd2,
    PWR_SLEEP = 2'd3
  } pwr_state_e;

  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/hbs_oc_filter.sv
module hbs_oc_filter #(
  parameter int DEG_CYC = 450
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_i,
  output logic trip_o
);
  localparam int CW = $clog2(DEG_CYC + 1);

  logic [CW-1:0] run_cnt;

  // count consecutive high samples, saturating so the trip fires once
  always_ff @(posedge clk) begin
    if (rst || !oc_i) begin
      run_cnt <= '0;
    end else if (run_cnt != CW'(DEG_CYC)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign trip_o = oc_i && (run_cnt == CW'(DEG_CYC - 1));

  generate
    if (DEG_CYC > 1) begin : g_chk
      // R4: a trip needs the flag to have been high on the previous edge too
      p_trip_after_run_r4: assert property (@(posedge clk) disable iff (rst)
        trip_o |-> $past(oc_i));
    end
  endgenerate

endmodule

// File: rtl/hbs_sleep_timer.sv
module hbs_sleep_timer #(
  parameter int CLR_CYC = 5000,
  parameter int SLP_CYC = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_n_i,
  output logic clr_o,
  output logic sleep_go_o
);
  localparam int CW = $clog2(SLP_CYC + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || sleep_n_i) begin
      low_cnt <= '0;
    end else if (low_cnt != CW'(SLP_CYC)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign clr_o      = !sleep_n_i && (low_cnt == CW'(CLR_CYC - 1));
  assign sleep_go_o = !sleep_n_i && (low_cnt == CW'(SLP_CYC - 1));

  generate
    if (SLP_CYC > 1) begin : g_chk
      // R8: sleep entry only after a low time longer than one sample
      p_sleep_after_low_r8: assert property (@(posedge clk) disable iff (rst)
        sleep_go_o |-> $past(!sleep_n_i));
    end
  endgenerate

endmodule

// File: rtl/hbs_fault_latch.sv
module hbs_fault_latch #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           uv_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] trip_i,
  input  logic           ot_i,
  output logic [NCH-1:0] oc_lat_o,
  output logic           ot_lat_o
);

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst || uv_i) begin
          oc_lat_o[ch] <= 1'b0;
        end else if (trip_i[ch]) begin
          oc_lat_o[ch] <= 1'b1;
        end else if (clr_i) begin
          oc_lat_o[ch] <= 1'b0;
        end
      end

      // R3: a latched channel holds until a clear or a supply undervoltage
      p_oc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (oc_lat_o[ch] && !clr_i && !uv_i) |=> oc_lat_o[ch]);
    end
  endgenerate

  // overtemperature only releases when the flag itself has dropped
  always_ff @(posedge clk) begin
    if (rst || uv_i) begin
      ot_lat_o <= 1'b0;
    end else begin
      ot_lat_o <= ot_i || (ot_lat_o && !clr_i);
    end
  end

  // R5: the latch can only fall on a clear or undervoltage
  p_ot_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ot_lat_o) |-> $past(clr_i || uv_i));

  // R7: a clear cannot release overtemperature while the flag is high
  p_ot_flag_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (ot_i && !uv_i) |=> ot_lat_o);

endmodule

// File: rtl/hbs_power_seq.sv
module hbs_power_seq
  import hbs_pkg::*;
#(
  parameter int WAKE_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       uv_i,
  input  logic       sleep_n_i,
  input  logic       sleep_go_i,
  output pwr_state_e state_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o  <= PWR_OFF;
      wake_cnt <= '0;
    end else if (uv_i) begin
      state_o  <= PWR_OFF;
      wake_cnt <= '0;
    end else begin
      unique case (state_o)
        PWR_OFF: begin
          state_o  <= PWR_WAKE;
          wake_cnt <= '0;
        end
        PWR_WAKE: begin
          if (sleep_go_i) begin
            state_o <= PWR_SLEEP;
          end else if (wake_cnt == CW'(WAKE_CYC - 1)) begin
            state_o <= PWR_RUN;
          end else begin
            wake_cnt <= wake_cnt + 1'b1;
          end
        end
        PWR_RUN: begin
          if (sleep_go_i) state_o <= PWR_SLEEP;
        end
        PWR_SLEEP: begin
          if (sleep_n_i) begin
            state_o  <= PWR_WAKE;
            wake_cnt <= '0;
          end
        end
        default: state_o <= PWR_OFF;
      endcase
    end
  end

  // R9: running is only reached through the wake interval
  p_run_via_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (state_o == PWR_RUN && $past(state_o) != PWR_RUN) |-> $past(state_o) == PWR_WAKE);

endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
  import hbs_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CLK_MHZ  = 250,
  parameter int OCP_NS   = 1800,
  parameter int CLR_NS   = 20000,
  parameter int SLEEP_NS = 120000,
  parameter int WAKE_NS  = 1000000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sleep_n_i,
  input  logic           uv_supply_i,
  input  logic           uv_pump_i,
  input  logic [NCH-1:0] oc_i,
  input  logic           ot_i,
  output logic [NCH-1:0] drv_en_o,
  output logic           pump_en_o,
  output logic           ready_o,
  output logic           fault_n_o
);
  localparam int DEG_CYC  = ns_to_cyc(OCP_NS, CLK_MHZ);
  localparam int CLR_CYC  = ns_to_cyc(CLR_NS, CLK_MHZ);
  localparam int SLP_CYC  = ns_to_cyc(SLEEP_NS, CLK_MHZ);
  localparam int WAKE_CYC = ns_to_cyc(WAKE_NS, CLK_MHZ);

  logic [NCH-1:0] trip;
  logic [NCH-1:0] oc_lat;
  logic           ot_lat;
  logic           clr_req;
  logic           sleep_go;
  pwr_state_e     pstate;

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_filt
      hbs_oc_filter #(.DEG_CYC(DEG_CYC)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .oc_i   (oc_i[ch]),
        .trip_o (trip[ch])
      );
    end
  endgenerate

  hbs_sleep_timer #(.CLR_CYC(CLR_CYC), .SLP_CYC(SLP_CYC)) u_slp (
    .clk        (clk),
    .rst        (rst),
    .sleep_n_i  (sleep_n_i),
    .clr_o      (clr_req),
    .sleep_go_o (sleep_go)
  );

  hbs_fault_latch #(.NCH(NCH)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .uv_i     (uv_supply_i),
    .clr_i    (clr_req),
    .trip_i   (trip),
    .ot_i     (ot_i),
    .oc_lat_o (oc_lat),
    .ot_lat_o (ot_lat)
  );

  hbs_power_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .uv_i       (uv_supply_i),
    .sleep_n_i  (sleep_n_i),
    .sleep_go_i (sleep_go),
    .state_o    (pstate)
  );

  logic running;
  logic powered;
  logic all_off;

  assign running = (pstate == PWR_RUN);
  assign powered = (pstate == PWR_RUN) || (pstate == PWR_WAKE);
  assign all_off = uv_supply_i || uv_pump_i || ot_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en_o  <= '0;
      pump_en_o <= 1'b0;
      ready_o   <= 1'b0;
      fault_n_o <= 1'b1;
    end else begin
      drv_en_o  <= {NCH{running && !all_off}} & ~oc_lat;
      pump_en_o <= powered && !uv_supply_i && !ot_lat;
      ready_o   <= running && !uv_supply_i;
      fault_n_o <= !(uv_supply_i || uv_pump_i || ot_lat || (|oc_lat));
    end
  end

  // R1: supply undervoltage darkens everything on the next edge
  p_uv_dark_r1: assert property (@(posedge clk) disable iff (rst)
    uv_supply_i |=> (drv_en_o == '0 && !pump_en_o && !ready_o && !fault_n_o));

  // R2: pump undervoltage stops drive and reports a fault
  p_cpuv_stop_r2: assert property (@(posedge clk) disable iff (rst)
    uv_pump_i |=> (drv_en_o == '0 && !fault_n_o));

  // R9: no drive while not ready
  p_notready_nodrive_r9: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> drv_en_o == '0);

  // R3: any channel held off while ready must be reported as a fault
  p_partial_drive_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (ready_o && drv_en_o != {NCH{1'b1}}) |-> !fault_n_o);

endmodule

// File: tb/sim_hb_fault_supervisor.sv
module sim_hb_fault_supervisor;
  localparam int NCH  = 4;
  localparam int DEG  = 10;
  localparam int CLR  = 20;
  localparam int SLP  = 60;
  localparam int WAKE = 50;

  logic           clk = 1'b0;
  logic           rst;
  logic           sleep_n_i;
  logic           uv_supply_i;
  logic           uv_pump_i;
  logic [NCH-1:0] oc_i;
  logic           ot_i;
  logic [NCH-1:0] drv_en_o;
  logic           pump_en_o;
  logic           ready_o;
  logic           fault_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_fault_supervisor #(
    .NCH(NCH), .CLK_MHZ(250), .OCP_NS(DEG*4), .CLR_NS(CLR*4),
    .SLEEP_NS(SLP*4), .WAKE_NS(WAKE*4)
  ) u0 (
    .clk(clk), .rst(rst), .sleep_n_i(sleep_n_i), .uv_supply_i(uv_supply_i),
    .uv_pump_i(uv_pump_i), .oc_i(oc_i), .ot_i(ot_i), .drv_en_o(drv_en_o),
    .pump_en_o(pump_en_o), .ready_o(ready_o), .fault_n_o(fault_n_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset_wake();
    rst = 1'b1; sleep_n_i = 1'b1; uv_supply_i = 1'b0; uv_pump_i = 1'b0;
    oc_i = '0; ot_i = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(1);
    check("R10 drv after reset", 32'(drv_en_o), 0);
    check("R10 ready after reset", 32'(ready_o), 0);
    check("R10 fault_n after reset", 32'(fault_n_o), 1);
    tick(WAKE - 1);
    check("R9 ready held in wake", 32'(ready_o), 0);
    check("R9 pump on in wake", 32'(pump_en_o), 1);
    tick(2);
    check("R9 ready after wake", 32'(ready_o), 1);
    check("R9 drive after wake", 32'(drv_en_o), 32'hF);
  endtask

  task automatic t_cpuv();
    uv_pump_i = 1'b1;
    tick(1);
    check("R2 drive off", 32'(drv_en_o), 0);
    check("R2 fault_n low", 32'(fault_n_o), 0);
    check("R2 pump kept", 32'(pump_en_o), 1);
    uv_pump_i = 1'b0;
    tick(1);
    check("R2 drive back", 32'(drv_en_o), 32'hF);
    check("R2 fault_n back", 32'(fault_n_o), 1);
    check("R2 ready kept", 32'(ready_o), 1);
  endtask

  task automatic t_oc();
    oc_i[2] = 1'b1; tick(DEG - 1); oc_i[2] = 1'b0; tick(2);
    check("R4 short overcurrent ignored", 32'(drv_en_o), 32'hF);
    oc_i[2] = 1'b1; tick(DEG - 1); oc_i[2] = 1'b0; tick(1);
    oc_i[2] = 1'b1; tick(DEG - 1); oc_i[2] = 1'b0; tick(2);
    check("R4 gap restarts count", 32'(drv_en_o), 32'hF);
    check("R4 no fault", 32'(fault_n_o), 1);
    oc_i[2] = 1'b1; tick(DEG); oc_i[2] = 1'b0; tick(2);
    check("R3 only ch2 off", 32'(drv_en_o), 32'hB);
    check("R3 fault_n low", 32'(fault_n_o), 0);
    check("R3 pump kept", 32'(pump_en_o), 1);
    tick(5);
    check("R3 latched", 32'(drv_en_o), 32'hB);
  endtask

  task automatic t_clear();
    sleep_n_i = 1'b0; tick(CLR - 1); sleep_n_i = 1'b1; tick(2);
    check("R6 short pulse clears nothing", 32'(drv_en_o), 32'hB);
    sleep_n_i = 1'b0; tick(CLR); sleep_n_i = 1'b1; tick(2);
    check("R6 pulse clears overcurrent", 32'(drv_en_o), 32'hF);
    check("R6 fault_n released", 32'(fault_n_o), 1);
    check("R6 no sleep", 32'(ready_o), 1);
  endtask

  task automatic t_sleep();
    sleep_n_i = 1'b0; tick(40); sleep_n_i = 1'b1; tick(2);
    check("R8 mid pulse stays awake", 32'(ready_o), 1);
    sleep_n_i = 1'b0; tick(SLP - 2);
    check("R8 awake before limit", 32'(ready_o), 1);
    tick(4);
    check("R8 asleep ready", 32'(ready_o), 0);
    check("R8 asleep drive", 32'(drv_en_o), 0);
    check("R8 asleep pump", 32'(pump_en_o), 0);
    sleep_n_i = 1'b1; tick(WAKE);
    check("R9 wake from sleep held", 32'(ready_o), 0);
    check("R9 pump during wake", 32'(pump_en_o), 1);
    tick(2);
    check("R9 ready after sleep wake", 32'(ready_o), 1);
    check("R9 drive after sleep wake", 32'(drv_en_o), 32'hF);
  endtask

  task automatic t_ot();
    ot_i = 1'b1; tick(2);
    check("R5 drive off", 32'(drv_en_o), 0);
    check("R5 pump off", 32'(pump_en_o), 0);
    check("R5 fault_n low", 32'(fault_n_o), 0);
    ot_i = 1'b0; tick(3);
    check("R5 latched after flag drop", 32'(drv_en_o), 0);
    ot_i = 1'b1;
    sleep_n_i = 1'b0; tick(CLR); sleep_n_i = 1'b1; tick(2);
    check("R7 clear blocked by flag", 32'(fault_n_o), 0);
    ot_i = 1'b0; tick(1);
    sleep_n_i = 1'b0; tick(CLR); sleep_n_i = 1'b1; tick(2);
    check("R7 clear after drop drive", 32'(drv_en_o), 32'hF);
    check("R7 clear after drop pump", 32'(pump_en_o), 1);
  endtask

  task automatic t_uv();
    oc_i[0] = 1'b1; tick(DEG); oc_i[0] = 1'b0; tick(2);
    check("R3 ch0 latched", 32'(drv_en_o), 32'hE);
    uv_supply_i = 1'b1; tick(1);
    check("R1 drive off", 32'(drv_en_o), 0);
    check("R1 pump off", 32'(pump_en_o), 0);
    check("R1 ready off", 32'(ready_o), 0);
    check("R1 fault_n low", 32'(fault_n_o), 0);
    tick(3);
    uv_supply_i = 1'b0; tick(1);
    check("R1 fault_n released", 32'(fault_n_o), 1);
    tick(WAKE - 1);
    check("R1 wake held after uv", 32'(ready_o), 0);
    tick(2);
    check("R1 ready after uv", 32'(ready_o), 1);
    check("R1 latch erased", 32'(drv_en_o), 32'hF);
  endtask

  initial begin
    t_reset_wake();
    t_cpuv();
    t_oc();
    t_clear();
    t_sleep();
    t_ot();
    t_uv();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule